// File: doc/BRIEF.md
# Trap and Illegal-Instruction Exception Entry Sequencer

This block is the exception-entry controller of a small 32-bit processor. Each cycle it looks at flags from the decode stage and decides whether the decoded instruction starts exception processing. Three causes are recognised: a software trap that carries an immediate vector number, a forbidden instruction that sits in the delay slot of a delayed branch, and undefined code found anywhere else. Detection happens when the offending instruction is decoded.

Once a cause is accepted, the sequencer holds fetch and decode stalled. It then runs a fixed sequence over a single request/acknowledge memory port. First it reads the handler address from the vector table. Next it pushes the status word onto the stack, and after that a program counter whose value depends on the cause. Finally it signals a redirect to the handler for one cycle. That redirect is a plain jump, with no delay slot.

Top module: `exc_entry_seq`

## Requirements
- R1: An exception is accepted only when `dec_valid` is high and `busy` is low. In a delay slot (`dec_in_slot`=1), any of `dec_undef`, `dec_wr_pc`, `dec_trap`, `dec_long`, `dec_bank_rst`, `dec_div_s` or `dec_div_u` raises a slot-illegal exception. Outside a slot, `dec_undef` raises a general-illegal exception and `dec_trap` raises a trap. Any other decoded instruction raises nothing: `busy` and `mem_req` stay low.
- R2: The vector read address is `vbr + 4*n`. Here n is `dec_trap_vec` for a trap, SLOT_VEC (default 6) for slot-illegal and ILL_VEC (default 4) for general-illegal.
- R3: The accesses happen in a fixed order. The first is a read of the vector address. The second writes the status word (sampled at detection) to `sp-4`. The third writes the saved program counter to `sp-8`, where sp is sampled at detection.
- R4: For a trap, the saved program counter is `dec_next_pc`, the address of the instruction after the trap.
- R5: For slot-illegal, the saved program counter is `dec_slot_tgt`, the jump target of the preceding delayed branch.
- R6: For general-illegal, the saved program counter is `dec_pc`, the address of the undefined code.
- R7: Priority is slot-illegal over general-illegal over trap. Undefined code outside a slot that also has `dec_trap` set is handled as general-illegal.
- R8: Each access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack` is sampled high. Only then does the sequence advance, whatever the latency.
- R9: `busy` rises in the cycle after detection and stays high through the redirect cycle. Decode inputs presented while `busy` is high are ignored and start no second sequence.
- R10: `redir_valid` is high for exactly one cycle. In that cycle `redir_pc` equals the word read from the vector table and `sp_new` equals `sp-8`. In the following cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_in_slot | input | 1 | Instruction sits in a delay slot |
| dec_trap | input | 1 | Instruction is a software trap |
| dec_trap_vec | input | VW | Trap immediate vector number |
| dec_undef | input | 1 | Instruction is undefined code |
| dec_wr_pc | input | 1 | Instruction writes the program counter |
| dec_long | input | 1 | Instruction is 32 bits long |
| dec_bank_rst | input | 1 | Instruction restores a register bank |
| dec_div_s | input | 1 | Signed divide |
| dec_div_u | input | 1 | Unsigned divide |
| dec_pc | input | AW | Address of the decoded instruction |
| dec_next_pc | input | AW | Address of the following instruction |
| dec_slot_tgt | input | AW | Target of the preceding delayed branch |
| sr_in | input | DW | Current status word |
| sp_in | input | AW | Current stack pointer |
| vbr | input | AW | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | DW | Read data, valid with ack |
| busy | output | 1 | Stall fetch and decode |
| redir_valid | output | 1 | Jump to handler this cycle |
| redir_pc | output | AW | Handler address |
| sp_new | output | AW | Stack pointer after both pushes |

## Verification
The bench targets the cases where causes interact. These are a trap flag on undefined code, a trap flagged in a delay slot, and each forbidden class in a slot taken one at a time. A wrong priority would push the wrong program counter or read the wrong vector. The bench also checks the saved program counter for each cause, because a design that mixes up next-pc, branch target and own address would resume the handler at the wrong place. Memory latency varies from zero to several cycles, which catches a sequencer that advances or changes its address before the acknowledge. Decode pulses sent while the sequencer is busy, and legal instructions, must start nothing. A broken stall would show up as a second, spurious sequence.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int VW       = 8,
  parameter int SLOT_VEC = 6,
  parameter int ILL_VEC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic          dec_in_slot,
  input  logic          dec_trap,
  input  logic [VW-1:0] dec_trap_vec,
  input  logic          dec_undef,
  input  logic          dec_wr_pc,
  input  logic          dec_long,
  input  logic          dec_bank_rst,
  input  logic          dec_div_s,
  input  logic          dec_div_u,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_next_pc,
  input  logic [AW-1:0] dec_slot_tgt,
  input  logic [DW-1:0] sr_in,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] vbr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic [AW-1:0] sp_new
);
  typedef enum logic [2:0] {S_IDLE, S_VEC, S_PSR, S_PPC, S_JMP} st_t;

  st_t           st;
  logic [AW-1:0] vec_addr_q, pc_q, sp_q, hnd_q;
  logic [DW-1:0] sr_q;

  logic          bad_slot, bad_gen, is_trap, take;
  logic [VW-1:0] vnum;
  logic [AW-1:0] save_pc;

  assign bad_slot = dec_in_slot & (dec_undef | dec_wr_pc | dec_trap | dec_long |
                                   dec_bank_rst | dec_div_s | dec_div_u);
  assign bad_gen  = ~dec_in_slot & dec_undef;
  assign is_trap  = ~dec_in_slot & ~dec_undef & dec_trap;
  assign take     = dec_valid & ~busy & (bad_slot | bad_gen | is_trap);

  assign vnum    = bad_slot ? VW'(SLOT_VEC) : bad_gen ? VW'(ILL_VEC) : dec_trap_vec;
  assign save_pc = bad_slot ? dec_slot_tgt : bad_gen ? dec_pc : dec_next_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      vec_addr_q <= '0;
      pc_q       <= '0;
      sp_q       <= '0;
      hnd_q      <= '0;
      sr_q       <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st         <= S_VEC;
          vec_addr_q <= vbr + (AW'(vnum) << 2);
          pc_q       <= save_pc;
          sp_q       <= sp_in;
          sr_q       <= sr_in;
        end
        S_VEC: if (mem_ack) begin
          hnd_q <= AW'(mem_rdata);
          st    <= S_PSR;
        end
        S_PSR: if (mem_ack) st <= S_PPC;
        S_PPC: if (mem_ack) st <= S_JMP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign mem_req     = (st == S_VEC) | (st == S_PSR) | (st == S_PPC);
  assign mem_we      = (st == S_PSR) | (st == S_PPC);
  assign mem_addr    = (st == S_VEC) ? vec_addr_q :
                       (st == S_PSR) ? sp_q - AW'(4) : sp_q - AW'(8);
  assign mem_wdata   = (st == S_PSR) ? sr_q : (st == S_PPC) ? DW'(pc_q) : '0;
  assign redir_valid = (st == S_JMP);
  assign redir_pc    = hnd_q;
  assign sp_new      = sp_q - AW'(8);

  assert_first_access_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req && !mem_we);

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_single_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid && !busy);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !redir_valid);

  assert_busy_ends_in_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(redir_valid));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int AW = 32, DW = 32, VW = 8;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, dec_in_slot = 0, dec_trap = 0, dec_undef = 0, dec_wr_pc = 0;
  logic dec_long = 0, dec_bank_rst = 0, dec_div_s = 0, dec_div_u = 0;
  logic [VW-1:0] dec_trap_vec = 0;
  logic [AW-1:0] dec_pc = 0, dec_next_pc = 0, dec_slot_tgt = 0, sp_in = 0, vbr = 0;
  logic [DW-1:0] sr_in = 0;
  logic mem_req, mem_we, mem_ack = 0, busy, redir_valid;
  logic [AW-1:0] mem_addr, redir_pc, sp_new;
  logic [DW-1:0] mem_wdata, mem_rdata = 0;

  int checks = 0, fails = 0, lat = 0, cnt = 0, nlog = 0;
  logic [31:0] log_addr [4];
  logic [31:0] log_data [4];
  logic        log_we   [4];

  always #4 clk = ~clk;

  exc_entry_seq u_dut (.*);

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; cnt = 0;
      end else if (mem_req) begin
        if (cnt >= lat) begin
          mem_ack = 1;
          mem_rdata = mem_addr ^ KEY;
          if (nlog < 4) begin
            log_addr[nlog] = mem_addr; log_data[nlog] = mem_wdata; log_we[nlog] = mem_we;
          end
          nlog++;
        end else cnt++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_dec();
    dec_valid = 0; dec_in_slot = 0; dec_trap = 0; dec_undef = 0; dec_wr_pc = 0;
    dec_long = 0; dec_bank_rst = 0; dec_div_s = 0; dec_div_u = 0;
  endtask

  task automatic pulse_dec();
    @(negedge clk);
    nlog = 0;
    dec_valid = 1;
    @(negedge clk);
    clear_dec();
  endtask

  task automatic expect_exc(string req, int vec, logic [31:0] spc);
    int n = 0;
    chk({req, " busy after detect (R9)"}, busy, 1);
    while (!redir_valid && n < 60) begin
      if (!busy) break;
      dec_valid = 1; dec_trap = 1; dec_trap_vec = 8'h33;
      @(negedge clk); n++;
      clear_dec();
    end
    chk({req, " redirect seen (R10)"}, redir_valid, 1);
    chk({req, " access count (R3)"}, nlog, 3);
    chk({req, " vector read addr (R2)"}, log_addr[0], vbr + 32'(vec) * 4);
    chk({req, " first is read (R3)"}, log_we[0], 0);
    chk({req, " SR push addr (R3)"}, log_addr[1], sp_in - 4);
    chk({req, " SR push data (R3)"}, log_data[1], sr_in);
    chk({req, " PC push addr (R3)"}, log_addr[2], sp_in - 8);
    chk({req, " saved PC"}, log_data[2], spc);
    chk({req, " handler (R10)"}, redir_pc, (vbr + 32'(vec) * 4) ^ KEY);
    chk({req, " sp_new (R10)"}, sp_new, sp_in - 8);
    @(negedge clk);
    chk({req, " no delay slot: busy low (R10)"}, busy, 0);
    chk({req, " redirect single cycle (R10)"}, redir_valid, 0);
    repeat (3) @(negedge clk);
    chk({req, " no second sequence (R9)"}, busy, 0);
  endtask

  task automatic expect_none(string req);
    for (int i = 0; i < 4; i++) begin
      chk({req, " legal: busy low (R1)"}, busy, 0);
      chk({req, " legal: no mem_req (R1)"}, mem_req, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_trap(logic [7:0] v, int l);
    lat = l; dec_trap = 1; dec_trap_vec = v;
    pulse_dec();
    expect_exc("R4 trap", v, dec_next_pc);
  endtask

  task automatic t_slot(int k);
    lat = k % 3; dec_in_slot = 1;
    case (k)
      0: dec_undef = 1;
      1: dec_wr_pc = 1;
      2: dec_long = 1;
      3: dec_bank_rst = 1;
      4: dec_div_s = 1;
      5: dec_div_u = 1;
      default: dec_trap = 1;
    endcase
    pulse_dec();
    expect_exc("R5 slot-illegal", 6, dec_slot_tgt);
  endtask

  task automatic t_general();
    lat = 4; dec_undef = 1;
    pulse_dec();
    expect_exc("R6 general-illegal", 4, dec_pc);
  endtask

  task automatic t_priority();
    lat = 1; dec_undef = 1; dec_trap = 1; dec_trap_vec = 8'h20;
    pulse_dec();
    expect_exc("R7 undef beats trap", 4, dec_pc);
    dec_in_slot = 1; dec_undef = 1; dec_trap = 1;
    pulse_dec();
    expect_exc("R7 slot beats general", 6, dec_slot_tgt);
  endtask

  task automatic t_legal();
    dec_long = 1; dec_div_s = 1; dec_wr_pc = 1;
    pulse_dec();
    expect_none("R1 out-of-slot classes");
    dec_in_slot = 1;
    pulse_dec();
    expect_none("R1 plain slot instr");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vbr = 32'h0000_1000; sp_in = 32'h0000_8000; sr_in = 32'h0000_00F0;
    dec_pc = 32'h0000_2040; dec_next_pc = 32'h0000_2042; dec_slot_tgt = 32'h0000_3300;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R1 reset mem_req", mem_req, 0);
    chk("R10 reset redirect", redir_valid, 0);
    rst_n = 1;
    @(negedge clk);
    t_trap(8'h21, 0);
    sp_in = 32'h0000_7FF0; sr_in = 32'h0000_0301;
    t_trap(8'hFF, 5);
    for (int k = 0; k < 7; k++) t_slot(k);
    t_general();
    t_priority();
    t_legal();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule